// File: doc/BRIEF.md
# Four-Way Page Translation Cache

This block keeps recently used page-table entries close to the address path so that a 20-bit virtual page number can be turned into a physical frame without walking the tables in memory. Pages are 4 KB and addresses are 32 bits wide. The page number is split into a set index and a tag. All four ways of the selected set are compared at once. One cycle later the block reports a hit or a miss. On a hit it also reports the stored 32-bit entry, a flag saying whether that entry came from the directory level or the table level, and the assembled physical address.

A separate fill port writes an entry fetched by an external walker into the indexed set. If the set already holds the same tag, that way is rewritten. Otherwise the fill takes the first invalid way. When the set is full, a per-set round-robin pointer chooses the victim. Two flush inputs are provided. A task-switch flush drops every entry except those marked global. A full flush drops everything and is meant for start-up.

Top module: `tlb_4way`

## Requirements
- R1: The set index is vpn[3:0] and the tag is vpn[19:4]. The buffer has 16 sets of 4 ways each, so entries that differ only in their index bits never evict one another.
- R2: rsp_valid is high in exactly the cycle after a cycle with lk_req high.
- R3: rsp_hit is high only when a valid entry in the indexed set holds the lookup tag. On a miss, rsp_pte, rsp_is_dir and rsp_paddr are zero.
- R4: On a hit, rsp_pte and rsp_is_dir equal the values most recently written for that page number.
- R5: On a hit, rsp_paddr is rsp_pte[31:12] followed by the 12-bit lk_off of the request.
- R6: A fill whose tag matches a valid way in its set rewrites that way. It creates no duplicate and does not advance the replacement pointer.
- R7: A fill with no tag match writes the lowest-numbered invalid way of the set, if there is one.
- R8: A fill into a full set evicts the way named by that set's round-robin pointer. The pointer is 0 after reset and advances by one (modulo 4) only on such an eviction.
- R9: flush_task invalidates every entry whose stored pte bit 8 (global) is 0 and keeps entries with bit 8 set.
- R10: flush_all invalidates every entry, global or not.
- R11: A lookup and a fill in the same cycle: the lookup sees the contents from before the fill, and the fill is visible to a lookup in the next cycle.
- R12: A fill presented in the same cycle as either flush is dropped.
- R13: After reset, rsp_valid and rsp_hit are low and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_off | input | 12 | Page offset carried into the physical address |
| fill_en | input | 1 | Write an entry |
| fill_vpn | input | 20 | Page number of the written entry |
| fill_pte | input | 32 | Page-table entry to store (bit 8 = global) |
| fill_is_dir | input | 1 | 1 = directory-level entry, 0 = table-level entry |
| flush_task | input | 1 | Drop all non-global entries |
| flush_all | input | 1 | Drop all entries |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pte | output | 32 | Cached entry on hit |
| rsp_is_dir | output | 1 | Entry-type flag on hit |
| rsp_paddr | output | 32 | Physical address on hit |

## Verification
Lookup and fill can land in the same cycle on the same page number. The bench raises both strobes together and then expects a miss, because the compare uses the contents from before the write. A second lookup in the very next cycle must hit with the new entry. A fill that coincides with a task flush is provoked the same way, and the next lookup of that page must miss.

// File: rtl/tlb_4way.sv
module tlb_4way #(
  parameter int VPN_W  = 20,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 4,
  parameter int WAYS   = 4,
  parameter int PTE_W  = 32,
  parameter int G_BIT  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [OFF_W-1:0] lk_off,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PTE_W-1:0] fill_pte,
  input  logic             fill_is_dir,
  input  logic             flush_task,
  input  logic             flush_all,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PTE_W-1:0] rsp_pte,
  output logic             rsp_is_dir,
  output logic [PTE_W-1:0] rsp_paddr
);
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int FRM_W = PTE_W - OFF_W;

  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  dir_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [PTE_W-1:0] pte_q [SETS][WAYS];
  logic [WAY_W-1:0] rr_q  [SETS];

  logic [IDX_W-1:0] lk_set, fl_set;
  logic [TAG_W-1:0] lk_tag, fl_tag;
  assign lk_set = lk_vpn[IDX_W-1:0];
  assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
  assign fl_set = fill_vpn[IDX_W-1:0];
  assign fl_tag = fill_vpn[VPN_W-1:IDX_W];

  logic [WAYS-1:0] lk_match, fl_match;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lk_match[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    assign fl_match[w] = vld_q[fl_set][w] && (tag_q[fl_set][w] == fl_tag);
  end

  logic             lk_any;
  logic [PTE_W-1:0] lk_pte;
  logic             lk_dir;
  always_comb begin
    lk_any = 1'b0;
    lk_pte = '0;
    lk_dir = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (lk_match[w]) begin
        lk_any = 1'b1;
        lk_pte = pte_q[lk_set][w];
        lk_dir = dir_q[lk_set][w];
      end
    end
  end

  logic             fl_go, fl_evict;
  logic [WAY_W-1:0] fl_way;
  logic             fl_found;
  assign fl_go = fill_en && !flush_task && !flush_all;
  always_comb begin
    fl_way   = rr_q[fl_set];
    fl_found = 1'b0;
    fl_evict = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_q[fl_set][w]) begin
        fl_way   = WAY_W'(w);
        fl_found = 1'b1;
      end
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (fl_match[w]) begin
        fl_way   = WAY_W'(w);
        fl_found = 1'b1;
      end
    end
    if (!fl_found) fl_evict = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else if (flush_all) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (flush_task) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          vld_q[s][w] <= vld_q[s][w] && pte_q[s][w][G_BIT];
    end else if (fl_go) begin
      vld_q[fl_set][fl_way] <= 1'b1;
      if (fl_evict) rr_q[fl_set] <= rr_q[fl_set] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fl_go) begin
      tag_q[fl_set][fl_way] <= fl_tag;
      pte_q[fl_set][fl_way] <= fill_pte;
      dir_q[fl_set][fl_way] <= fill_is_dir;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_pte    <= '0;
      rsp_is_dir <= 1'b0;
      rsp_paddr  <= '0;
    end else begin
      rsp_valid  <= lk_req;
      rsp_hit    <= lk_req && lk_any;
      rsp_pte    <= (lk_req && lk_any) ? lk_pte : '0;
      rsp_is_dir <= lk_req && lk_any && lk_dir;
      rsp_paddr  <= (lk_req && lk_any) ? {lk_pte[PTE_W-1:PTE_W-FRM_W], lk_off} : '0;
    end
  end

  a_r2_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(lk_req));

  a_r3_hit_in_response: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && lk_any) |=> rsp_paddr[OFF_W-1:0] == $past(lk_off));

  a_r10_flush_all_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all ##1 lk_req) |=> !rsp_hit);

  a_r9_task_flush_keeps_global: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_task ##1 lk_req) |=> (!rsp_hit || rsp_pte[G_BIT]));

  a_r11_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_go ##1 (lk_req && lk_vpn == $past(fill_vpn))) |=> rsp_hit);
endmodule

// File: tb/tb_tlb_4way.sv
module tb_tlb_4way;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic [11:0] lk_off = '0;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [31:0] fill_pte = '0;
  logic        fill_is_dir = 1'b0;
  logic        flush_task = 1'b0;
  logic        flush_all = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_is_dir;
  logic [31:0] rsp_pte, rsp_paddr;

  int checks = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  tlb_4way dut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_off(lk_off),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pte(fill_pte), .fill_is_dir(fill_is_dir),
    .flush_task(flush_task), .flush_all(flush_all), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_pte(rsp_pte), .rsp_is_dir(rsp_is_dir), .rsp_paddr(rsp_paddr)
  );

  typedef struct packed {
    logic        is_fill;
    logic [19:0] vpn;
    logic [31:0] pte;
    logic        dir;
    logic        hit;
    logic [79:0] req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 20'h00010, 32'hAAAAA003, 1'b0, 1'b0, "R7"},
    '{1'b0, 20'h00010, 32'hAAAAA003, 1'b0, 1'b1, "R4"},
    '{1'b0, 20'h00020, 32'h0,        1'b0, 1'b0, "R3"},
    '{1'b0, 20'h00011, 32'h0,        1'b0, 1'b0, "R1"},
    '{1'b1, 20'h00020, 32'h12345107, 1'b1, 1'b0, "R7"},
    '{1'b0, 20'h00020, 32'h12345107, 1'b1, 1'b1, "R4"},
    '{1'b0, 20'h00010, 32'hAAAAA003, 1'b0, 1'b1, "R1"},
    '{1'b1, 20'h00010, 32'hBBBBB001, 1'b0, 1'b0, "R6"},
    '{1'b0, 20'h00010, 32'hBBBBB001, 1'b0, 1'b1, "R6"}
  };

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [19:0] v, input logic [31:0] p, input logic d);
    fill_en = 1'b1; fill_vpn = v; fill_pte = p; fill_is_dir = d;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic look(input logic [19:0] v, input logic [11:0] o, input logic eh,
                      input logic [31:0] ep, input logic ed, input string req);
    lk_req = 1'b1; lk_vpn = v; lk_off = o;
    @(negedge clk);
    lk_req = 1'b0;
    chk(rsp_valid == 1'b1, {req, " valid"}, 64'(rsp_valid), 64'd1);
    chk(rsp_hit == eh, {req, " hit"}, 64'(rsp_hit), 64'(eh));
    if (eh) begin
      chk(rsp_pte == ep, {req, " pte"}, 64'(rsp_pte), 64'(ep));
      chk(rsp_is_dir == ed, {req, " dir"}, 64'(rsp_is_dir), 64'(ed));
      chk(rsp_paddr == {ep[31:12], o}, {req, " paddr"}, 64'(rsp_paddr), 64'({ep[31:12], o}));
    end else begin
      chk(rsp_pte == 32'h0 && rsp_paddr == 32'h0, {req, " miss zero"}, 64'(rsp_pte), 64'd0);
    end
  endtask

  initial begin
    repeat (CLK_P * 2000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(rsp_valid == 1'b0 && rsp_hit == 1'b0, "R13 in reset", 64'({rsp_valid, rsp_hit}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2 idle", 64'(rsp_valid), 64'd0);
    look(20'h00000, 12'h000, 1'b0, 32'h0, 1'b0, "R13");

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_fill) fill(VECS[i].vpn, VECS[i].pte, VECS[i].dir);
      else look(VECS[i].vpn, 12'h5A5, VECS[i].hit, VECS[i].pte, VECS[i].dir, string'(VECS[i].req));
    end

    // R5 offset
    look(20'h00020, 12'hABC, 1'b1, 32'h12345107, 1'b1, "R5");

    // R8 round robin in set 0: ways 0..3 = tags 1,2,3,4
    fill(20'h00030, 32'h33333000, 1'b0);
    fill(20'h00040, 32'h44444000, 1'b0);
    fill(20'h00050, 32'h55555000, 1'b0);
    look(20'h00010, 12'h0, 1'b0, 32'h0, 1'b0, "R8 way0 evicted");
    look(20'h00050, 12'h0, 1'b1, 32'h55555000, 1'b0, "R8");
    look(20'h00020, 12'h0, 1'b1, 32'h12345107, 1'b1, "R8 way1 kept");
    fill(20'h00060, 32'h66666000, 1'b0);
    look(20'h00020, 12'h0, 1'b0, 32'h0, 1'b0, "R8 way1 evicted");
    look(20'h00030, 12'h0, 1'b1, 32'h33333000, 1'b0, "R8 way2 kept");

    // R7 invalid first after task flush in set 7
    fill(20'h000A7, 32'hA0000000, 1'b0);
    fill(20'h000B7, 32'hB0000100, 1'b0);
    fill(20'h000C7, 32'hC0000000, 1'b0);
    fill(20'h000D7, 32'hD0000000, 1'b0);
    flush_task = 1'b1; @(negedge clk); flush_task = 1'b0;
    look(20'h000B7, 12'h0, 1'b1, 32'hB0000100, 1'b0, "R9 global kept");
    look(20'h000A7, 12'h0, 1'b0, 32'h0, 1'b0, "R9 non-global dropped");
    look(20'h00030, 12'h0, 1'b0, 32'h0, 1'b0, "R9 other set dropped");
    fill(20'h000E7, 32'hE0000000, 1'b0);
    look(20'h000B7, 12'h0, 1'b1, 32'hB0000100, 1'b0, "R7 invalid way used");
    look(20'h000E7, 12'h0, 1'b1, 32'hE0000000, 1'b0, "R7");

    // R10 full flush
    flush_all = 1'b1; @(negedge clk); flush_all = 1'b0;
    look(20'h000B7, 12'h0, 1'b0, 32'h0, 1'b0, "R10 global dropped");

    // R11 same-cycle lookup and fill
    fill_en = 1'b1; fill_vpn = 20'h00305; fill_pte = 32'h30500000; fill_is_dir = 1'b1;
    look(20'h00305, 12'h0, 1'b0, 32'h0, 1'b0, "R11 pre-fill view");
    fill_en = 1'b0;
    look(20'h00305, 12'h0, 1'b1, 32'h30500000, 1'b1, "R11 next cycle");

    // R12 fill with flush dropped
    fill_en = 1'b1; fill_vpn = 20'h00409; fill_pte = 32'h40900100; fill_is_dir = 1'b0;
    flush_task = 1'b1;
    @(negedge clk);
    fill_en = 1'b0; flush_task = 1'b0;
    look(20'h00409, 12'h0, 1'b0, 32'h0, 1'b0, "R12 fill dropped");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule